// File: doc/BRIEF.md
# Dipulse Line Encoder and Decoder

This block sits between a serial bit stream in NRZ form and a transformer-coupled line driver that uses dipulse signalling at 2.5 Mbps. Every bit occupies a fixed cell of 400 ns, timed from a 20 MHz system clock as eight ticks of 50 ns. On the transmit side, a one is sent as two short active-low pulses on two separate outputs, one after the other. A zero sends nothing, and both outputs stay high. Transmit bits enter one per cell through a valid/ready handshake, so a steady source can keep the line busy without gaps between cells.

On the receive side, the input is a positive pulse for each one and is idle for each zero. The input passes through a synchroniser and a rising-edge detector. Nothing is emitted until the first pulse arrives. That pulse locks a bit-cell counter, and from then on the block emits one decoded bit per cell with a single-cycle strobe. The counter then tracks the pulses that follow, so a pulse that arrives up to two ticks (100 ns) early or late relative to the nominal 400 ns grid still lands in the correct cell. A second edge inside a cell that has already seen a one is discarded.

Top module: `dipulse_codec`

## Requirements
- R1: After a one is accepted, `tx_pulse_a_n` is low for exactly the first 2 clocks of the cell, starting in the clock after acceptance. `tx_pulse_b_n` is then low for exactly the next 2 clocks, and the two outputs are never low together.
- R2: For an accepted zero, both `tx_pulse_a_n` and `tx_pulse_b_n` stay high for the whole 8-clock cell.
- R3: `tx_ready` is high while the transmitter is idle and in the last clock of each cell, and low in the other 7 clocks. This lets back-to-back bits be accepted exactly every 8 clocks.
- R4: After reset, `rx_valid` stays low until the first rising edge is seen on `rx_line`.
- R5: Once locked, `rx_valid` pulses high for one clock per cell, and the strobes are spaced 8 clocks apart while the pulses arrive on the nominal grid.
- R6: A pulse train on the nominal grid is decoded into `rx_bit` in order. A cell with a pulse gives 1 and a cell without one gives 0, and the cell of the locking pulse is the first bit emitted.
- R7: Pulses displaced by up to ±2 clocks from their nominal grid position, in any mix of early and late, are still decoded into the correct bits.
- R8: A second rising edge within a cell that has already recorded a one is ignored. The following empty cell still decodes as 0.
- R9: During reset, both pulse outputs are high, `tx_ready` is high and `rx_valid` is low.
- R10: A long high level on `rx_line` counts as a single one. Only its rising edge matters, so the next cell without an edge decodes as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 8 ticks per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit bit offered |
| tx_ready | output | 1 | Transmitter accepts a bit this clock |
| tx_bit | input | 1 | NRZ bit to transmit |
| tx_pulse_a_n | output | 1 | First active-low pulse of a transmitted one |
| tx_pulse_b_n | output | 1 | Second active-low pulse of a transmitted one |
| rx_line | input | 1 | Positive receive pulses from the line interface |
| rx_valid | output | 1 | One-clock strobe per decoded cell |
| rx_bit | output | 1 | Decoded NRZ bit, valid with `rx_valid` |

## Verification
Several properties are checked on every clock:
- the two transmit pulses never overlap;
- the second pulse only ever starts right after the first;
- a zero never drives either output low;
- the receive strobe never lasts more than one clock, and it stays silent before lock;
- a repeated edge never clears a recorded one.

Other behaviour shows only in the bench scenarios, because it depends on a whole stream: the exact pulse widths and cell positions, back-to-back handshake timing, and whether jittered, doubled or stretched receive pulses decode to the intended bit sequence.

// File: rtl/dipulse_pkg.sv
package dipulse_pkg;

   localparam int DEF_CELL_TICKS   = 8;
   localparam int DEF_PULSE_TICKS  = 2;
   localparam int DEF_JITTER_TICKS = 2;
   localparam int DEF_SYNC_STAGES  = 2;

   typedef enum logic {
      RX_HUNT  = 1'b0,
      RX_TRACK = 1'b1
   } rx_mode_e;

endpackage

// File: rtl/dipulse_tx.sv
module dipulse_tx #(
   parameter int CELL_TICKS  = dipulse_pkg::DEF_CELL_TICKS,
   parameter int PULSE_TICKS = dipulse_pkg::DEF_PULSE_TICKS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic in_ready,
   input  logic in_bit,
   output logic pulse_a_n,
   output logic pulse_b_n
);
   localparam int CW = $clog2(CELL_TICKS);
   localparam logic [CW-1:0] LAST_TICK = CW'(CELL_TICKS - 1);
   localparam logic [CW-1:0] A_END     = CW'(PULSE_TICKS);
   localparam logic [CW-1:0] B_END     = CW'(2 * PULSE_TICKS);

   logic [CW-1:0] tick_q;
   logic          busy_q;
   logic          bit_q;
   logic          accept;

   assign in_ready = !busy_q || (tick_q == LAST_TICK);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tick_q <= '0;
         bit_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         tick_q <= '0;
         bit_q  <= in_bit;
      end else if (busy_q) begin
         if (tick_q == LAST_TICK) begin
            busy_q <= 1'b0;
            tick_q <= '0;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   always_comb begin
      pulse_a_n = !(busy_q && bit_q && (tick_q < A_END));
      pulse_b_n = !(busy_q && bit_q && (tick_q >= A_END) && (tick_q < B_END));
   end

   p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(!pulse_a_n && !pulse_b_n));

   p_b_after_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_b_n) |-> $past(!pulse_a_n));

   p_zero_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_bit) |=> (pulse_a_n && pulse_b_n));

   p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready);

endmodule

// File: rtl/dipulse_rx_sync.sv
module dipulse_rx_sync #(
   parameter int STAGES = dipulse_pkg::DEF_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic rise
);
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= line_in;
   end

   for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign rise = chain_q[STAGES-1] && !chain_q[STAGES];

   p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/dipulse_rx_cell.sv
module dipulse_rx_cell #(
   parameter int CELL_TICKS   = dipulse_pkg::DEF_CELL_TICKS,
   parameter int JITTER_TICKS = dipulse_pkg::DEF_JITTER_TICKS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic out_valid,
   output logic out_bit
);
   import dipulse_pkg::*;

   localparam int CW = $clog2(CELL_TICKS);
   localparam int SLOT = CELL_TICKS / 2;
   localparam logic [CW-1:0] LAST_TICK  = CW'(CELL_TICKS - 1);
   localparam logic [CW-1:0] LOCK_NEXT  = CW'(SLOT + 1);
   localparam logic [CW-1:0] LATE_EDGE  = CW'(SLOT + JITTER_TICKS);
   localparam logic [CW-1:0] EARLY_EDGE = CW'(SLOT - JITTER_TICKS);

   rx_mode_e      mode_q;
   logic [CW-1:0] tick_q;
   logic          seen_q;
   logic          fresh;
   logic          late;
   logic          early;

   assign fresh = (mode_q == RX_TRACK) && rise && !seen_q;
   assign late  = fresh && (tick_q >= LATE_EDGE);
   assign early = fresh && (tick_q <= EARLY_EDGE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= RX_HUNT;
         tick_q    <= '0;
         seen_q    <= 1'b0;
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else if (mode_q == RX_HUNT) begin
         out_valid <= 1'b0;
         if (rise) begin
            mode_q <= RX_TRACK;
            seen_q <= 1'b1;
            tick_q <= LOCK_NEXT;
         end
      end else begin
         out_valid <= 1'b0;
         if (late) begin
            seen_q <= 1'b1;
         end else if (tick_q == LAST_TICK) begin
            out_valid <= 1'b1;
            out_bit   <= seen_q;
            seen_q    <= 1'b0;
            tick_q    <= '0;
         end else if (early) begin
            seen_q <= 1'b1;
            tick_q <= tick_q + CW'(2);
         end else begin
            if (fresh) seen_q <= 1'b1;
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   p_hunt_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RX_HUNT) |=> !out_valid);

   p_lock_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RX_HUNT && rise) |=> (mode_q == RX_TRACK));

   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_repeat_edge_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RX_TRACK && seen_q && tick_q != LAST_TICK) |=> seen_q);

endmodule

// File: rtl/dipulse_codec.sv
module dipulse_codec #(
   parameter int CELL_TICKS   = dipulse_pkg::DEF_CELL_TICKS,
   parameter int PULSE_TICKS  = dipulse_pkg::DEF_PULSE_TICKS,
   parameter int JITTER_TICKS = dipulse_pkg::DEF_JITTER_TICKS,
   parameter int SYNC_STAGES  = dipulse_pkg::DEF_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_valid,
   output logic tx_ready,
   input  logic tx_bit,
   output logic tx_pulse_a_n,
   output logic tx_pulse_b_n,
   input  logic rx_line,
   output logic rx_valid,
   output logic rx_bit
);
   if (CELL_TICKS < 4) begin : g_bad_cell
      $error("dipulse_codec: CELL_TICKS must be at least 4");
   end
   if (PULSE_TICKS < 1 || 2 * PULSE_TICKS > CELL_TICKS) begin : g_bad_pulse
      $error("dipulse_codec: two pulses must fit inside one cell");
   end
   if (JITTER_TICKS < 1 || 4 * JITTER_TICKS > CELL_TICKS) begin : g_bad_jitter
      $error("dipulse_codec: JITTER_TICKS must lie in 1..CELL_TICKS/4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dipulse_codec: at least two synchroniser stages required");
   end

   logic rx_rise;

   dipulse_tx #(
      .CELL_TICKS (CELL_TICKS),
      .PULSE_TICKS(PULSE_TICKS)
   ) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .in_bit   (tx_bit),
      .pulse_a_n(tx_pulse_a_n),
      .pulse_b_n(tx_pulse_b_n)
   );

   dipulse_rx_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(rx_line),
      .rise   (rx_rise)
   );

   dipulse_rx_cell #(
      .CELL_TICKS  (CELL_TICKS),
      .JITTER_TICKS(JITTER_TICKS)
   ) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rx_rise),
      .out_valid(rx_valid),
      .out_bit  (rx_bit)
   );

endmodule

// File: tb/dipulse_codec_tb_top.sv
module dipulse_codec_tb_top;
   logic clk = 1'b0;
   logic rst_n;
   logic tx_valid, tx_ready, tx_bit, tx_pulse_a_n, tx_pulse_b_n;
   logic rx_line, rx_valid, rx_bit;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rxn = 0;
   logic rx_bits [0:63];
   int   rx_time [0:63];

   logic txb [0:15];
   logic pb  [0:15];
   int   po  [0:15];
   logic lvl [0:255];

   always #10 clk = ~clk;

   dipulse_codec dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
      .tx_pulse_a_n(tx_pulse_a_n), .tx_pulse_b_n(tx_pulse_b_n),
      .rx_line(rx_line), .rx_valid(rx_valid), .rx_bit(rx_bit)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rx_valid && rxn < 64) begin
         rx_bits[rxn] = rx_bit;
         rx_time[rxn] = cyc;
         rxn = rxn + 1;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tx_valid = 1'b0; tx_bit = 1'b0; rx_line = 1'b0;
      repeat (3) @(negedge clk);
      rxn = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R9: idle outputs during reset
   task automatic test_reset();
      rst_n = 1'b0; tx_valid = 1'b0; rx_line = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_pulse_a_n === 1'b1, "R9 pulse_a idle", int'(tx_pulse_a_n), 1);
      chk(tx_pulse_b_n === 1'b1, "R9 pulse_b idle", int'(tx_pulse_b_n), 1);
      chk(tx_ready === 1'b1, "R9 ready", int'(tx_ready), 1);
      chk(rx_valid === 1'b0, "R9 rx_valid", int'(rx_valid), 0);
      do_reset();
   endtask

   // R1 R2 R3: back-to-back transmit, cell by cell
   task automatic test_tx(input int n, input string tag);
      logic ea, eb;
      do_reset();
      chk(tx_ready === 1'b1, "R3 idle ready", int'(tx_ready), 1);
      tx_valid = 1'b1; tx_bit = txb[0];
      @(posedge clk);
      for (int k = 0; k < n; k++) begin
         for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            ea = !(txb[k] && j < 2);
            eb = !(txb[k] && j >= 2 && j < 4);
            if (txb[k]) begin
               chk(tx_pulse_a_n === ea, {"R1 pulse_a ", tag}, int'(tx_pulse_a_n), int'(ea));
               chk(tx_pulse_b_n === eb, {"R1 pulse_b ", tag}, int'(tx_pulse_b_n), int'(eb));
            end else begin
               chk(tx_pulse_a_n === 1'b1, {"R2 pulse_a ", tag}, int'(tx_pulse_a_n), 1);
               chk(tx_pulse_b_n === 1'b1, {"R2 pulse_b ", tag}, int'(tx_pulse_b_n), 1);
            end
            chk(tx_ready === (j == 7), {"R3 ready ", tag}, int'(tx_ready), int'(j == 7));
            if (j == 7) begin
               if (k + 1 < n) tx_bit = txb[k+1];
               else           tx_valid = 1'b0;
            end
         end
      end
      @(negedge clk);
      chk(tx_pulse_a_n && tx_pulse_b_n, {"R2 idle after ", tag}, int'(tx_pulse_a_n & tx_pulse_b_n), 1);
      chk(tx_ready === 1'b1, {"R3 ready after ", tag}, int'(tx_ready), 1);
   endtask

   // Drive a pulse train: kind 0 normal, 1 doubled first cell, 2 stretched first cell
   task automatic drive_rx(input int n, input int kind);
      int total;
      total = 8 * (n + 5);
      for (int t = 0; t < 256; t++) lvl[t] = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (pb[i]) begin
            int b;
            b = 8 + 8 * i + po[i];
            lvl[b] = 1'b1; lvl[b+1] = 1'b1;
            if (i == 0 && kind == 1) begin lvl[b+3] = 1'b1; lvl[b+4] = 1'b1; end
            if (i == 0 && kind == 2) for (int q = 2; q < 6; q++) lvl[b+q] = 1'b1;
         end
      end
      for (int t = 0; t < total; t++) begin
         rx_line = lvl[t];
         @(negedge clk);
      end
      rx_line = 1'b0;
   endtask

   task automatic test_rx(input int n, input int kind, input string req);
      do_reset();
      drive_rx(n, kind);
      chk(rxn >= n, {req, " strobe count"}, rxn, n);
      for (int i = 0; i < n; i++) begin
         if (i < rxn)
            chk(rx_bits[i] === pb[i], {req, " decoded bit"}, int'(rx_bits[i]), int'(pb[i]));
      end
   endtask

   // R4: no strobe before the first edge
   task automatic test_hunt();
      do_reset();
      repeat (40) @(negedge clk);
      chk(rxn == 0, "R4 silent before lock", rxn, 0);
   endtask

   // R5: strobe spacing on the nominal grid
   task automatic test_spacing();
      for (int i = 0; i < 6; i++) begin pb[i] = (i % 2 == 0); po[i] = 0; end
      test_rx(6, 0, "R6 grid");
      for (int i = 1; i < 6; i++)
         if (i < rxn)
            chk(rx_time[i] - rx_time[i-1] == 8, "R5 strobe spacing",
                rx_time[i] - rx_time[i-1], 8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      test_reset();

      txb[0] = 1; txb[1] = 0; txb[2] = 1; txb[3] = 1; txb[4] = 0; txb[5] = 0; txb[6] = 1;
      test_tx(7, "mixed");
      txb[0] = 0; txb[1] = 0;
      test_tx(2, "zeros");

      test_hunt();
      test_spacing();

      pb[0] = 1; pb[1] = 1; pb[2] = 0; pb[3] = 1; pb[4] = 0; pb[5] = 0; pb[6] = 1;
      for (int i = 0; i < 7; i++) po[i] = 0;
      test_rx(7, 0, "R6 pattern");

      pb[0] = 1; po[0] = 0;  pb[1] = 1; po[1] = 2;  pb[2] = 1; po[2] = -2;
      pb[3] = 1; po[3] = 2;  pb[4] = 1; po[4] = -2; pb[5] = 0; po[5] = 0;
      pb[6] = 1; po[6] = 0;  pb[7] = 1; po[7] = -2; pb[8] = 0; po[8] = 0;
      pb[9] = 1; po[9] = 2;  pb[10] = 1; po[10] = 1; pb[11] = 1; po[11] = -1;
      test_rx(12, 0, "R7 jitter");

      pb[0] = 1; pb[1] = 0; pb[2] = 1; pb[3] = 0;
      for (int i = 0; i < 4; i++) po[i] = 0;
      test_rx(4, 1, "R8 second edge");
      test_rx(4, 2, "R10 long level");

      summary();
   end
endmodule